// File: doc/BRIEF.md
# Compressed Immediate-Format Instruction Decoder

This block turns one 16-bit compressed instruction of the immediate-based format into an expanded micro-op for a downstream execution pipeline. The format is valid only while the front end is in 16-bit mode and both mode-control bits of the halfword (bit 15 and bit 0) are set. In every other case the block flags the halfword as not applicable and produces no operation. When the format applies, a 3-bit sub-opcode picks one of these classes: add-immediate, add-immediate-shifted, compare-immediate, integer load or floating-point load. A size-select bit refines the compare and load classes.

The immediate is split across two fields that are not adjacent. The block joins them with the single high bit as the sign, sign-extends the result to the machine width and then scales it. Add-immediate-shifted moves it up by 16. Loads are aligned implicitly to their access size. A base register of zero turns the add forms into load-immediate forms. Sub-opcodes outside the format raise an illegal-instruction flag. The result is registered, so the micro-op appears one clock after the instruction is presented.

Top module: `cimm_decoder`

## Requirements
- R1: After a synchronous reset, out_valid is 0 until an instruction is presented.
- R2: out_valid is high exactly one clock after each cycle in which valid_in is high, and low otherwise. The other outputs belong to the instruction presented in that earlier cycle.
- R3: If in16_mode is 0, insn[15] is 0 or insn[0] is 0, the result has out_na=1, out_illegal=0, out_op=0 (none), out_rc=0, out_size=0 and zero register and immediate fields.
- R4: The raw immediate is the 5-bit signed value {insn[14], insn[4:1]}, with insn[14] as the sign. It is sign-extended to XLEN bits before any scaling.
- R5: Sub-opcode insn[10:8]=010 with a non-zero base insn[7:5] gives op 1 (add-immediate). It also gives out_rt=insn[13:11], out_ra=insn[7:5], out_rc=1 and the unscaled immediate.
- R6: Sub-opcode 011 with a non-zero base gives op 2 (add-immediate-shifted), with out_rc=1 and the immediate shifted left by 16.
- R7: With a base of zero, sub-opcode 010 becomes op 3 (load-immediate) and 011 becomes op 4 (load-immediate-shifted), with out_ra=0 and the immediate scaled as in R5 and R6.
- R8: Sub-opcode 100 is compare-immediate. insn[13]=0 gives op 5 (doubleword) and 1 gives op 6 (word). out_rt is the condition field insn[12:11], out_ra=insn[7:5], out_rc=0 and the immediate is unscaled.
- R9: Sub-opcode 101 is integer load, with out_rt=insn[12:11] and out_ra=insn[7:5]. insn[13]=0 gives op 7, size 8 and the immediate shifted left by 3. insn[13]=1 gives op 8, size 4 and the immediate shifted left by 2.
- R10: Sub-opcode 110 is float load. insn[13]=0 gives op 9 (single), size 4 and a shift of 2. insn[13]=1 gives op 10 (double), size 8 and a shift of 3. The register fields are as in R9.
- R11: Sub-opcodes 000, 001 and 111 in an applicable halfword give out_illegal=1, out_na=0, op 0, out_rc=0, size 0 and zero register and immediate fields.
- R12: out_size is 0 for every result that is not a load, and out_na and out_illegal are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | An instruction is presented this cycle |
| in16_mode | input | 1 | Front end is currently in 16-bit mode |
| insn | input | 16 | Compressed instruction halfword |
| out_valid | output | 1 | Micro-op valid |
| out_na | output | 1 | Format not applicable to this halfword |
| out_illegal | output | 1 | Unlisted sub-opcode |
| out_op | output | 4 | Micro-op code (see R5 to R10) |
| out_rc | output | 1 | Operation records to the condition register |
| out_rt | output | REG_W | Destination register or condition field |
| out_ra | output | REG_W | Base or source register |
| out_imm | output | XLEN | Sign-extended, scaled immediate |
| out_size | output | 4 | Load access size in bytes, 0 if not a load |

## Verification
The hardest cases to reach are the boundaries of the immediate: the most negative raw value 10000 scaled by 16, 3 and 2, where a sign that is not extended before the shift shows as wrong high bits. The bench drives every sub-opcode with both signs, zero bases for both add forms, and each mode-bit combination that blocks the format. It then runs a long stream of random halfwords with idle gaps, so that scaling, register selection and the one-cycle latency are checked across back-to-back and isolated issues.

// File: rtl/cimm_pkg.sv
package cimm_pkg;

    typedef enum logic [3:0] {
        UOP_NONE  = 4'd0,
        UOP_ADDI  = 4'd1,
        UOP_ADDIS = 4'd2,
        UOP_LI    = 4'd3,
        UOP_LIS   = 4'd4,
        UOP_CMPD  = 4'd5,
        UOP_CMPW  = 4'd6,
        UOP_LD    = 4'd7,
        UOP_LW    = 4'd8,
        UOP_LFS   = 4'd9,
        UOP_LFD   = 4'd10
    } uop_e;

    typedef enum logic [2:0] {
        SUB_ADD  = 3'b010,
        SUB_ADDS = 3'b011,
        SUB_CMP  = 3'b100,
        SUB_ILD  = 3'b101,
        SUB_FLD  = 3'b110
    } sub_e;

    // Halfword layout, most significant field first.
    typedef struct packed {
        logic       mode_hi;   // [15]
        logic       imm_sign;  // [14]
        logic [2:0] dst;       // [13:11], [13] doubles as size select
        logic [2:0] sub;       // [10:8]
        logic [2:0] src;       // [7:5]
        logic [3:0] offs;      // [4:1]
        logic       mode_lo;   // [0]
    } cfmt_t;

    localparam int RAW_IMM_W = 5;

    function automatic logic [RAW_IMM_W-1:0] raw_imm(input cfmt_t f);
        return {f.imm_sign, f.offs};
    endfunction

    // Left shift applied to the sign-extended immediate per micro-op.
    function automatic logic [4:0] imm_shift(input uop_e op);
        case (op)
            UOP_ADDIS, UOP_LIS: return 5'd16;
            UOP_LD, UOP_LFD:    return 5'd3;
            UOP_LW, UOP_LFS:    return 5'd2;
            default:            return 5'd0;
        endcase
    endfunction

    function automatic logic [3:0] access_bytes(input uop_e op);
        case (op)
            UOP_LD, UOP_LFD: return 4'd8;
            UOP_LW, UOP_LFS: return 4'd4;
            default:         return 4'd0;
        endcase
    endfunction

    function automatic logic is_load(input uop_e op);
        return (op == UOP_LD) || (op == UOP_LW) || (op == UOP_LFS) || (op == UOP_LFD);
    endfunction

endpackage

// File: rtl/cimm_gate.sv
module cimm_gate
    import cimm_pkg::*;
(
    input  logic  in16_mode,
    input  cfmt_t fmt,
    output logic  applies
);
    always_comb begin
        applies = in16_mode && fmt.mode_hi && fmt.mode_lo;
    end
endmodule

// File: rtl/cimm_classify.sv
module cimm_classify
    import cimm_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  cfmt_t            fmt,
    output uop_e             op,
    output logic             illegal,
    output logic             rc,
    output logic [REG_W-1:0] rt,
    output logic [REG_W-1:0] ra
);
    localparam int DST_W  = 3;
    localparam int NARR_W = 2;

    logic             base_zero;
    logic             sel_alt;
    logic [REG_W-1:0] dst_wide;
    logic [REG_W-1:0] dst_narrow;
    logic [REG_W-1:0] src_wide;

    generate
        if (REG_W > DST_W) begin : g_pad
            assign dst_wide   = {{(REG_W-DST_W){1'b0}}, fmt.dst};
            assign src_wide   = {{(REG_W-DST_W){1'b0}}, fmt.src};
        end else begin : g_trim
            assign dst_wide   = fmt.dst[REG_W-1:0];
            assign src_wide   = fmt.src[REG_W-1:0];
        end
        if (REG_W > NARR_W) begin : g_npad
            assign dst_narrow = {{(REG_W-NARR_W){1'b0}}, fmt.dst[NARR_W-1:0]};
        end else begin : g_ntrim
            assign dst_narrow = fmt.dst[REG_W-1:0];
        end
    endgenerate

    always_comb begin
        base_zero = (fmt.src == 3'b000);
        sel_alt   = fmt.dst[DST_W-1];
        op        = UOP_NONE;
        illegal   = 1'b0;
        rc        = 1'b0;
        rt        = '0;
        ra        = '0;
        case (fmt.sub)
            SUB_ADD: begin
                op = base_zero ? UOP_LI : UOP_ADDI;
                rc = 1'b1;
                rt = dst_wide;
                ra = src_wide;
            end
            SUB_ADDS: begin
                op = base_zero ? UOP_LIS : UOP_ADDIS;
                rc = 1'b1;
                rt = dst_wide;
                ra = src_wide;
            end
            SUB_CMP: begin
                op = sel_alt ? UOP_CMPW : UOP_CMPD;
                rt = dst_narrow;
                ra = src_wide;
            end
            SUB_ILD: begin
                op = sel_alt ? UOP_LW : UOP_LD;
                rt = dst_narrow;
                ra = src_wide;
            end
            SUB_FLD: begin
                op = sel_alt ? UOP_LFD : UOP_LFS;
                rt = dst_narrow;
                ra = src_wide;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cimm_immgen.sv
module cimm_immgen
    import cimm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cfmt_t           fmt,
    input  uop_e            op,
    output logic [XLEN-1:0] imm
);
    localparam int EXT_W = XLEN - RAW_IMM_W;

    logic [RAW_IMM_W-1:0] raw;
    logic [XLEN-1:0]      sext;

    always_comb begin
        raw  = raw_imm(fmt);
        sext = {{EXT_W{raw[RAW_IMM_W-1]}}, raw};
        imm  = sext << imm_shift(op);
    end
endmodule

// File: rtl/cimm_decoder.sv
module cimm_decoder
    import cimm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic             in16_mode,
    input  logic [15:0]      insn,
    output logic             out_valid,
    output logic             out_na,
    output logic             out_illegal,
    output logic [3:0]       out_op,
    output logic             out_rc,
    output logic [REG_W-1:0] out_rt,
    output logic [REG_W-1:0] out_ra,
    output logic [XLEN-1:0]  out_imm,
    output logic [3:0]       out_size
);
    typedef struct packed {
        logic             na;
        logic             illegal;
        uop_e             op;
        logic             rc;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [XLEN-1:0]  imm;
        logic [3:0]       size;
    } uop_t;

    cfmt_t            fmt;
    logic             applies;
    uop_e             cls_op;
    logic             cls_illegal;
    logic             cls_rc;
    logic [REG_W-1:0] cls_rt;
    logic [REG_W-1:0] cls_ra;
    logic [XLEN-1:0]  gen_imm;
    uop_t             nxt;
    uop_t             cur;
    logic             vld_q;

    assign fmt = cfmt_t'(insn);

    cimm_gate u_gate (
        .in16_mode (in16_mode),
        .fmt       (fmt),
        .applies   (applies)
    );

    cimm_classify #(.REG_W(REG_W)) u_classify (
        .fmt     (fmt),
        .op      (cls_op),
        .illegal (cls_illegal),
        .rc      (cls_rc),
        .rt      (cls_rt),
        .ra      (cls_ra)
    );

    cimm_immgen #(.XLEN(XLEN)) u_immgen (
        .fmt (fmt),
        .op  (cls_op),
        .imm (gen_imm)
    );

    always_comb begin
        nxt = '0;
        nxt.op = UOP_NONE;
        if (!applies) begin
            nxt.na = 1'b1;
        end else if (cls_illegal) begin
            nxt.illegal = 1'b1;
        end else begin
            nxt.op   = cls_op;
            nxt.rc   = cls_rc;
            nxt.rt   = cls_rt;
            nxt.ra   = cls_ra;
            nxt.imm  = gen_imm;
            nxt.size = access_bytes(cls_op);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= valid_in;
            if (valid_in) begin
                cur <= nxt;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_na      = cur.na;
    assign out_illegal = cur.illegal;
    assign out_op      = cur.op;
    assign out_rc      = cur.rc;
    assign out_rt      = cur.rt;
    assign out_ra      = cur.ra;
    assign out_imm     = cur.imm;
    assign out_size    = cur.size;
endmodule

// File: rtl/cimm_decoder_chk.sv
module cimm_decoder_chk #(
    parameter int XLEN  = 64,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic             in16_mode,
    input logic [15:0]      insn,
    input logic             out_valid,
    input logic             out_na,
    input logic             out_illegal,
    input logic [3:0]       out_op,
    input logic             out_rc,
    input logic [REG_W-1:0] out_rt,
    input logic [REG_W-1:0] out_ra,
    input logic [XLEN-1:0]  out_imm,
    input logic [3:0]       out_size
);
    assert_issue_latency_R2: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> out_valid);

    assert_idle_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !out_valid);

    assert_blocked_format_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !(in16_mode && insn[15] && insn[0])) |=> (out_na && out_op == 4'd0));

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_na && out_illegal));

    assert_wide_load_align_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_op == 4'd7 || out_op == 4'd10)) |-> (out_size == 4'd8 && out_imm[2:0] == 3'b000));

    assert_narrow_load_align_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_op == 4'd8 || out_op == 4'd9)) |-> (out_size == 4'd4 && out_imm[1:0] == 2'b00));

    assert_nonload_size_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_op >= 4'd7 && out_op <= 4'd10)) |-> out_size == 4'd0);

    assert_unscaled_sext_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_op == 4'd1 || out_op == 4'd5 || out_op == 4'd6))
        |-> ($countones(out_imm[XLEN-1:4]) == 0 || $countones(out_imm[XLEN-1:4]) == XLEN-4));

    assert_illegal_subop_R11: assert property (@(posedge clk) disable iff (rst)
        (valid_in && in16_mode && insn[15] && insn[0] && (insn[10:8] == 3'b000 || insn[10:8] == 3'b001 || insn[10:8] == 3'b111))
        |=> (out_illegal && out_op == 4'd0));

    assert_zero_base_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && in16_mode && insn[15] && insn[0] && insn[10:8] == 3'b010 && insn[7:5] == 3'b000)
        |=> (out_op == 4'd3 && out_ra == '0));
endmodule

bind cimm_decoder cimm_decoder_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_in    (valid_in),
    .in16_mode   (in16_mode),
    .insn        (insn),
    .out_valid   (out_valid),
    .out_na      (out_na),
    .out_illegal (out_illegal),
    .out_op      (out_op),
    .out_rc      (out_rc),
    .out_rt      (out_rt),
    .out_ra      (out_ra),
    .out_imm     (out_imm),
    .out_size    (out_size)
);

// File: tb/cimm_decoder_bench.sv
module cimm_decoder_bench;
    localparam int XLEN  = 64;
    localparam int REG_W = 5;

    typedef struct {
        logic             na;
        logic             ill;
        logic [3:0]       op;
        logic             rc;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [XLEN-1:0]  imm;
        logic [3:0]       size;
        int               cyc;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_in = 1'b0;
    logic             in16_mode = 1'b0;
    logic [15:0]      insn = '0;
    logic             out_valid, out_na, out_illegal, out_rc;
    logic [3:0]       out_op, out_size;
    logic [REG_W-1:0] out_rt, out_ra;
    logic [XLEN-1:0]  out_imm;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    bit   done     = 0;
    exp_t sb[$];

    cimm_decoder #(.XLEN(XLEN), .REG_W(REG_W)) u_cimm_decoder (
        .clk(clk), .rst(rst), .valid_in(valid_in), .in16_mode(in16_mode), .insn(insn),
        .out_valid(out_valid), .out_na(out_na), .out_illegal(out_illegal), .out_op(out_op),
        .out_rc(out_rc), .out_rt(out_rt), .out_ra(out_ra), .out_imm(out_imm), .out_size(out_size)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic m16, input logic [15:0] w);
        exp_t e;
        logic [XLEN-1:0] base;
        logic [2:0] sub;
        e.na = 0; e.ill = 0; e.op = 0; e.rc = 0; e.rt = 0; e.ra = 0; e.imm = 0; e.size = 0;
        sub  = w[10:8];
        base = {{(XLEN-5){w[14]}}, w[14], w[4:1]};
        if (!(m16 && w[15] && w[0])) begin
            e.na = 1; e.tag = "R3";
        end else begin
            case (sub)
                3'b010, 3'b011: begin
                    e.rc = 1; e.rt = REG_W'(w[13:11]); e.ra = REG_W'(w[7:5]);
                    e.imm = (sub == 3'b011) ? (base << 16) : base;
                    if (w[7:5] == 0) begin e.op = (sub == 3'b011) ? 4'd4 : 4'd3; e.tag = "R7"; end
                    else begin e.op = (sub == 3'b011) ? 4'd2 : 4'd1; e.tag = (sub == 3'b011) ? "R6" : "R5"; end
                end
                3'b100: begin
                    e.op = w[13] ? 4'd6 : 4'd5; e.rt = REG_W'(w[12:11]); e.ra = REG_W'(w[7:5]);
                    e.imm = base; e.tag = "R8";
                end
                3'b101: begin
                    e.op = w[13] ? 4'd8 : 4'd7; e.rt = REG_W'(w[12:11]); e.ra = REG_W'(w[7:5]);
                    e.size = w[13] ? 4'd4 : 4'd8; e.imm = w[13] ? (base << 2) : (base << 3); e.tag = "R9";
                end
                3'b110: begin
                    e.op = w[13] ? 4'd10 : 4'd9; e.rt = REG_W'(w[12:11]); e.ra = REG_W'(w[7:5]);
                    e.size = w[13] ? 4'd8 : 4'd4; e.imm = w[13] ? (base << 3) : (base << 2); e.tag = "R10";
                end
                default: begin e.ill = 1; e.tag = "R11"; end
            endcase
        end
        return e;
    endfunction

    task automatic drive(input logic m16, input logic [15:0] w);
        exp_t e;
        @(negedge clk);
        e = model(m16, w);
        e.cyc = cyc;
        sb.push_back(e);
        valid_in = 1; in16_mode = m16; insn = w;
        @(negedge clk);
        valid_in = 0;
    endtask

    function automatic logic [15:0] mk(input logic s, input logic [2:0] d, input logic [2:0] sub,
                                       input logic [2:0] src, input logic [3:0] offs);
        return {1'b1, s, d, sub, src, offs, 1'b1};
    endfunction

    // Monitor: compare each produced result against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc - 1 == e.cyc, "R2", "latency", XLEN'(cyc - 1), XLEN'(e.cyc));
                    check(out_na == e.na, e.tag, "na", out_na, e.na);
                    check(out_illegal == e.ill, e.tag, "illegal", out_illegal, e.ill);
                    check(out_op == e.op, e.tag, "op", out_op, e.op);
                    check(out_rc == e.rc, e.tag, "rc", out_rc, e.rc);
                    check(out_rt == e.rt, e.tag, "rt", out_rt, e.rt);
                    check(out_ra == e.ra, e.tag, "ra", out_ra, e.ra);
                    check(out_imm == e.imm, (e.tag == "R5") ? "R4" : e.tag, "imm", out_imm, e.imm);
                    check(out_size == e.size, (e.size == 0) ? "R12" : e.tag, "size", out_size, e.size);
                    check(!(out_na && out_illegal), "R12", "na and illegal together", {out_na, out_illegal}, 0);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        // Blocked format: each mode condition alone
        drive(0, mk(0, 3'd1, 3'b010, 3'd2, 4'd3));
        drive(1, mk(0, 3'd1, 3'b010, 3'd2, 4'd3) & 16'h7FFF);
        drive(1, mk(0, 3'd1, 3'b010, 3'd2, 4'd3) & 16'hFFFE);
        // Add forms, both signs, extreme values
        drive(1, mk(0, 3'd5, 3'b010, 3'd3, 4'hF));   // R5 +15
        drive(1, mk(1, 3'd7, 3'b010, 3'd1, 4'h0));   // R4 -16
        drive(1, mk(1, 3'd2, 3'b011, 3'd6, 4'h0));   // R6 -16<<16
        drive(1, mk(0, 3'd4, 3'b010, 3'd0, 4'h9));   // R7 li
        drive(1, mk(1, 3'd3, 3'b011, 3'd0, 4'h1));   // R7 lis
        // Compare
        drive(1, mk(1, 3'b011, 3'b100, 3'd5, 4'h2)); // R8 cmpd
        drive(1, mk(0, 3'b110, 3'b100, 3'd7, 4'h8)); // R8 cmpw
        // Loads
        drive(1, mk(1, 3'b001, 3'b101, 3'd2, 4'h0)); // R9 ld
        drive(1, mk(0, 3'b110, 3'b101, 3'd4, 4'hF)); // R9 lw
        drive(1, mk(1, 3'b010, 3'b110, 3'd1, 4'h0)); // R10 lfs
        drive(1, mk(0, 3'b111, 3'b110, 3'd3, 4'h5)); // R10 lfd
        // Illegal sub-opcodes
        drive(1, mk(0, 3'd1, 3'b000, 3'd1, 4'h1));   // R11
        drive(1, mk(1, 3'd2, 3'b001, 3'd2, 4'h2));   // R11
        drive(1, mk(0, 3'd3, 3'b111, 3'd3, 4'h3));   // R11
        // Back-to-back issue
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            logic [15:0] w;
            w = mk(i[0], 3'(i), 3'(2 + (i % 5)), 3'(i + 1), 4'(i * 3));
            e = model(1, w);
            e.cyc = cyc;
            sb.push_back(e);
            valid_in = 1; in16_mode = 1; insn = w;
            @(negedge clk);
        end
        valid_in = 0;
        // Random stream with gaps
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w;
            logic m;
            w = 16'($urandom);
            m = ($urandom % 8) != 0;
            if ($urandom % 4 != 0) w = w | 16'h8001;
            drive(m, w);
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", XLEN'(sb.size()), 0);
        check(out_valid == 0, "R2", "idle out_valid", out_valid, 0);
        finish_run();
    end
endmodule